// File: doc/BRIEF.md
# NAND Flash Bus Cycle Sequencer

This block turns single-byte requests into the pin-level strobes of an 8-bit asynchronous NAND flash: command-latch cycles, address-latch cycles, data-write cycles and data-read cycles. All phase lengths are expressed in half periods of a flash clock of period T. The block's own clock runs at twice the flash clock rate, so every edge lands on a T/2 boundary. This half-period grain is what the read strobe needs: it stays low for 1.5T and high for 0.5T.

A requester presents an operation code and, for writes, a byte, with a valid flag. The sequencer accepts the request only while idle. It raises `busy` until the last strobe phase of that cycle has finished. Read cycles wait for the flash ready line to have been high continuously for 21T, measured after a two-stage synchronizer. The byte present on the data inputs is captured at the clock edge that lifts the read strobe. It is returned with a one-clock valid pulse. The data bus output enable is dropped for reads. Before the first write that follows reset or a read, the enable gets a lead of one T before the write data moves.

Top module: `nand_cycle_seq`

## Requirements
- R1: After reset, busy, rd_valid, fl_cle, fl_ale and fl_dq_oe are 0, and fl_we_n and fl_re_n are 1.
- R2: Op codes are 2'b00 command, 2'b01 address, 2'b10 data write and 2'b11 read. In a write cycle, fl_we_n stays high for 1T after the data is set up, then goes low for exactly 1T, then stays high for a further 1T before the cycle ends.
- R3: fl_cle is high only in command cycles and fl_ale only in address cycles, never both. Each is raised 1T before fl_we_n falls and held until 1T after fl_we_n rises.
- R4: fl_dq_o carries the request byte from 2T before the fl_we_n rising edge until at least 1T after it, and is stable while fl_we_n is low.
- R5: A read releases fl_dq_oe at acceptance and keeps it low while fl_re_n is low. The first write after reset or after a read raises fl_dq_oe 1T before loading the new byte. Later writes load the byte at once.
- R6: In a read cycle, fl_re_n is low for exactly 1.5T and then high for 0.5T before busy clears.
- R7: fl_re_n does not fall until fl_ready has been high without a break for 21T after its two-stage synchronizer. A drop of fl_ready restarts the count. With the default clocking, fl_re_n falls 45 clocks after the first clock edge that follows a rise of fl_ready.
- R8: rd_data takes the value of fl_dq_i at the edge where fl_re_n rises. rd_valid is high for exactly that one clock.
- R9: busy is high from the clock after acceptance until the cycle ends. Requests presented while busy are ignored and start no further cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock, twice the flash clock rate |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_op | input | 2 | Operation code |
| req_data | input | 8 | Byte for command, address or data write |
| busy | output | 1 | Cycle in progress; requests ignored |
| rd_valid | output | 1 | One-clock pulse with a captured read byte |
| rd_data | output | 8 | Captured read byte |
| fl_cle | output | 1 | Command latch enable |
| fl_ale | output | 1 | Address latch enable |
| fl_we_n | output | 1 | Write strobe, active low |
| fl_re_n | output | 1 | Read strobe, active low |
| fl_dq_o | output | 8 | Data bus output value |
| fl_dq_oe | output | 1 | Data bus output enable |
| fl_dq_i | input | 8 | Data bus input value |
| fl_ready | input | 1 | Flash ready (1) / busy (0), asynchronous |

## Verification
Each write kind is swept over several computed byte values, both as the first write after a read and as a follow-on write. Every output is compared clock by clock, which separates the lead phase from the direct path and CLE from ALE. Reads place the expected byte on the bus for only the single clock before the strobe rises, with a different value on either side. A capture one edge early or late therefore returns the wrong byte. A ready line that rises, drops and rises again checks that the 21T count restarts and ends on the exact clock. Requests of a different kind held during every busy cycle show that nothing is accepted early.

// File: rtl/nand_seq_pkg.sv
// Shared types for the NAND cycle sequencer.
// Assumes: op codes are fixed by the request interface contract.
package nand_seq_pkg;
    typedef enum logic [1:0] {
        OP_CMD   = 2'b00,
        OP_ADDR  = 2'b01,
        OP_WDATA = 2'b10,
        OP_READ  = 2'b11
    } fop_t;

    typedef enum logic [2:0] {
        ST_IDLE, ST_LEAD, ST_SETUP, ST_WLOW, ST_WHOLD,
        ST_RWAIT, ST_RLOW, ST_RHIGH
    } fstate_t;

    // Phase lengths in half flash periods (T/2).
    localparam int LEAD_H  = 2;
    localparam int SETUP_H = 2;
    localparam int WLOW_H  = 2;
    localparam int WHOLD_H = 2;
    localparam int RLOW_H  = 3;
    localparam int RHIGH_H = 1;
endpackage

// File: rtl/fl_half_tick.sv
// Half-period tick generator: pulses once every HALF_DIV clocks.
// Assumes: clr restarts the count so that phases align to request acceptance.
module fl_half_tick #(
    parameter int HALF_DIV = 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    output logic tick
);
    localparam int CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;

    logic [CW-1:0] cnt;

    assign tick = (cnt == CW'(HALF_DIV - 1));

    // Divider counter, restarted on clear.
    always_ff @(posedge clk) begin
        if (!rst_n || clr || tick) cnt <= '0;
        else                       cnt <= cnt + 1'b1;
    end

    AST_TICK_CNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        int'(cnt) < HALF_DIV); // R2
endmodule

// File: rtl/fl_ready_timer.sv
// Synchronizes the flash ready line and reports when it has stayed high
// for WAIT_CLKS consecutive clocks. Any low sample restarts the count.
// Assumes: SYNC_STAGES >= 2.
module fl_ready_timer #(
    parameter int SYNC_STAGES = 2,
    parameter int WAIT_CLKS   = 42
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ready_async,
    output logic rdy_ok
);
    localparam int TW = $clog2(WAIT_CLKS + 1);

    logic [SYNC_STAGES-1:0] sync_q;
    logic                   rdy_s;
    logic [TW-1:0]          cnt;

    assign rdy_s  = sync_q[SYNC_STAGES-1];
    assign rdy_ok = (cnt == TW'(WAIT_CLKS));

    // Two-or-more stage synchronizer for the asynchronous ready line.
    always_ff @(posedge clk) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= {sync_q[SYNC_STAGES-2:0], ready_async};
    end

    // Saturating count of consecutive synchronized-high clocks.
    always_ff @(posedge clk) begin
        if (!rst_n || !rdy_s) cnt <= '0;
        else if (!rdy_ok)     cnt <= cnt + 1'b1;
    end

    AST_TIMER_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        int'(cnt) <= WAIT_CLKS); // R7
    AST_TIMER_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        !rdy_s |=> (cnt == '0)); // R7
endmodule

// File: rtl/nand_cycle_seq.sv
// NAND flash bus cycle sequencer: issues one command, address, data-write
// or data-read cycle per accepted request, timed in half flash periods.
// Assumes: clk is twice the flash clock times HALF_DIV, and the flash
// clock is at most 50 MHz; fl_ready is asynchronous.
module nand_cycle_seq
    import nand_seq_pkg::*;
#(
    parameter int DATA_W      = 8,
    parameter int HALF_DIV    = 1,
    parameter int READY_T     = 21,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [1:0]        req_op,
    input  logic [DATA_W-1:0] req_data,
    output logic              busy,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data,
    output logic              fl_cle,
    output logic              fl_ale,
    output logic              fl_we_n,
    output logic              fl_re_n,
    output logic [DATA_W-1:0] fl_dq_o,
    output logic              fl_dq_oe,
    input  logic [DATA_W-1:0] fl_dq_i,
    input  logic              fl_ready
);
    localparam int WAIT_CLKS = 2 * READY_T * HALF_DIV;
    localparam int PH_W      = 2;

    fstate_t           st;
    fop_t              op_q;
    logic [PH_W-1:0]   ph;
    logic [DATA_W-1:0] wdata_q;
    logic              tick, rdy_ok, accept, ph_done, latch_win;

    assign accept = req_valid && (st == ST_IDLE);

    fl_half_tick #(.HALF_DIV(HALF_DIV)) u_tick (
        .clk(clk), .rst_n(rst_n), .clr(accept), .tick(tick)
    );

    fl_ready_timer #(.SYNC_STAGES(SYNC_STAGES), .WAIT_CLKS(WAIT_CLKS)) u_rdy (
        .clk(clk), .rst_n(rst_n), .ready_async(fl_ready), .rdy_ok(rdy_ok)
    );

    // Phase length in half periods for the current state.
    function automatic int ph_len(input fstate_t s);
        case (s)
            ST_LEAD:  return LEAD_H;
            ST_SETUP: return SETUP_H;
            ST_WLOW:  return WLOW_H;
            ST_WHOLD: return WHOLD_H;
            ST_RLOW:  return RLOW_H;
            ST_RHIGH: return RHIGH_H;
            default:  return 1;
        endcase
    endfunction

    // Phase completion: timed phases by count, ready wait by timer.
    always_comb begin
        if (st == ST_RWAIT) ph_done = tick && rdy_ok;
        else                ph_done = tick && (int'(ph) == ph_len(st) - 1);
    end

    // Cycle state machine with data, enable and capture registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st       <= ST_IDLE;
            op_q     <= OP_CMD;
            ph       <= '0;
            wdata_q  <= '0;
            fl_dq_o  <= '0;
            fl_dq_oe <= 1'b0;
            rd_valid <= 1'b0;
            rd_data  <= '0;
        end else begin
            rd_valid <= 1'b0;
            if (st == ST_IDLE) begin
                if (req_valid) begin
                    op_q    <= fop_t'(req_op);
                    ph      <= '0;
                    wdata_q <= req_data;
                    if (fop_t'(req_op) == OP_READ) begin
                        st       <= ST_RWAIT;
                        fl_dq_oe <= 1'b0;
                    end else if (!fl_dq_oe) begin
                        st       <= ST_LEAD;
                        fl_dq_oe <= 1'b1;
                    end else begin
                        st      <= ST_SETUP;
                        fl_dq_o <= req_data;
                    end
                end
            end else if (ph_done) begin
                ph <= '0;
                case (st)
                    ST_LEAD: begin
                        st      <= ST_SETUP;
                        fl_dq_o <= wdata_q;
                    end
                    ST_SETUP: st <= ST_WLOW;
                    ST_WLOW:  st <= ST_WHOLD;
                    ST_RWAIT: st <= ST_RLOW;
                    ST_RLOW: begin
                        st       <= ST_RHIGH;
                        rd_data  <= fl_dq_i;
                        rd_valid <= 1'b1;
                    end
                    default:  st <= ST_IDLE;
                endcase
            end else if (tick) begin
                ph <= ph + 1'b1;
            end
        end
    end

    // Pin decode from the state register.
    always_comb begin
        latch_win = (st == ST_SETUP) || (st == ST_WLOW) || (st == ST_WHOLD);
        fl_cle    = latch_win && (op_q == OP_CMD);
        fl_ale    = latch_win && (op_q == OP_ADDR);
        fl_we_n   = (st != ST_WLOW);
        fl_re_n   = (st != ST_RLOW);
        busy      = (st != ST_IDLE);
    end

    AST_CLE_ALE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(fl_cle && fl_ale)); // R3
    AST_STROBES_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(!fl_we_n && !fl_re_n)); // R2
    AST_WDATA_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        !fl_we_n |-> ($stable(fl_dq_o) && fl_dq_oe)); // R4
    AST_OE_OFF_READ: assert property (@(posedge clk) disable iff (!rst_n)
        !fl_re_n |-> !fl_dq_oe); // R5
    AST_RE_AFTER_READY: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(fl_re_n) |-> $past(rdy_ok)); // R7
    AST_CAPTURE_AT_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> $rose(fl_re_n)); // R8
    AST_STROBE_ONLY_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (!fl_we_n || !fl_re_n) |-> busy); // R9
endmodule

// File: tb/nand_cycle_seq_tb.sv
// Self-checking bench: sweeps every op kind over computed bytes and checks
// all pins clock by clock against arithmetic expectations (HALF_DIV = 1).
module nand_cycle_seq_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       req_valid = 1'b0;
    logic [1:0] req_op = 2'b00;
    logic [7:0] req_data = 8'h00;
    logic       busy, rd_valid, fl_cle, fl_ale, fl_we_n, fl_re_n, fl_dq_oe;
    logic [7:0] rd_data, fl_dq_o;
    logic [7:0] fl_dq_i = 8'h00;
    logic       fl_ready = 1'b0;

    int  checks = 0;
    int  errors = 0;
    bit  oe_m = 1'b0;
    bit  finished = 1'b0;

    always #10 clk = ~clk;

    nand_cycle_seq u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
        .req_data(req_data), .busy(busy), .rd_valid(rd_valid),
        .rd_data(rd_data), .fl_cle(fl_cle), .fl_ale(fl_ale),
        .fl_we_n(fl_we_n), .fl_re_n(fl_re_n), .fl_dq_o(fl_dq_o),
        .fl_dq_oe(fl_dq_oe), .fl_dq_i(fl_dq_i), .fl_ready(fl_ready)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    // One write cycle; junk read requests are held while busy (R9).
    task automatic do_write(input logic [1:0] op, input logic [7:0] d);
        int lead = oe_m ? 0 : 2;
        @(negedge clk);
        req_valid = 1'b1; req_op = op; req_data = d;
        @(posedge clk);
        for (int k = 0; k <= lead + 7; k++) begin
            @(negedge clk);
            chk("R9 busy", busy, (k < lead + 6) ? 1 : 0);
            chk("R2 we_n", fl_we_n, (k >= lead + 2 && k < lead + 4) ? 0 : 1);
            chk("R3 cle", fl_cle, (op == 2'b00 && k >= lead && k < lead + 6) ? 1 : 0);
            chk("R3 ale", fl_ale, (op == 2'b01 && k >= lead && k < lead + 6) ? 1 : 0);
            chk("R5 oe", fl_dq_oe, 1);
            chk("R2 re_n", fl_re_n, 1);
            if (k >= lead) chk("R4 dq_o", fl_dq_o, d);
            if (k < lead + 5) begin
                req_valid = 1'b1; req_op = 2'b11; req_data = ~d;
            end else begin
                req_valid = 1'b0;
            end
            @(posedge clk);
        end
        oe_m = 1'b1;
    endtask

    // One read cycle with ready long settled; byte valid only at capture edge.
    task automatic do_read(input logic [7:0] v);
        @(negedge clk);
        req_valid = 1'b1; req_op = 2'b11; fl_dq_i = ~v;
        @(posedge clk);
        for (int k = 0; k <= 6; k++) begin
            @(negedge clk);
            chk("R6 re_n", fl_re_n, (k >= 1 && k <= 3) ? 0 : 1);
            chk("R9 busy", busy, (k < 5) ? 1 : 0);
            chk("R5 oe", fl_dq_oe, 0);
            chk("R8 rd_valid", rd_valid, (k == 4) ? 1 : 0);
            chk("R2 we_n", fl_we_n, 1);
            if (k == 4) chk("R8 rd_data", rd_data, v);
            if (k < 4) begin
                req_valid = 1'b1; req_op = 2'b10; req_data = v;
            end else begin
                req_valid = 1'b0;
            end
            fl_dq_i = (k == 3) ? v : ~v;
            @(posedge clk);
        end
        oe_m = 1'b0;
    endtask

    initial begin
        int n;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        chk("R1 busy", busy, 0);
        chk("R1 rd_valid", rd_valid, 0);
        chk("R1 cle", fl_cle, 0);
        chk("R1 ale", fl_ale, 0);
        chk("R1 oe", fl_dq_oe, 0);
        chk("R1 we_n", fl_we_n, 1);
        chk("R1 re_n", fl_re_n, 1);
        fl_ready = 1'b1;
        repeat (60) @(posedge clk);

        // Main sweep: every op kind, first and follow-on writes (R2 R3 R4 R5).
        for (int rep = 0; rep < 4; rep++) begin
            do_write(2'b00, 8'((rep * 37 + 5) & 8'hFF));
            do_write(2'b01, 8'((rep * 91 + 160) & 8'hFF));
            do_write(2'b10, 8'((rep * 73 + 255) & 8'hFF));
            do_write(2'b10, 8'((rep * 19) & 8'hFF));
            do_read(8'((rep * 53 + 90) & 8'hFF));   // R6 R8
        end

        // R7: ready wait with an interrupted first rise.
        @(negedge clk);
        fl_ready = 1'b0; fl_dq_i = 8'h3C;
        repeat (5) @(negedge clk);
        req_valid = 1'b1; req_op = 2'b11;
        @(negedge clk);
        req_valid = 1'b0;
        fl_ready = 1'b1;
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            chk("R7 early re_n", fl_re_n, 1);
        end
        fl_ready = 1'b0;
        for (int i = 0; i < 5; i++) begin
            @(negedge clk);
            chk("R7 drop re_n", fl_re_n, 1);
        end
        fl_ready = 1'b1;
        n = 0;
        do begin
            @(posedge clk);
            n++;
            @(negedge clk);
        end while (fl_re_n && n < 200);
        chk("R7 latency", n, 45);
        for (int i = 0; i < 3; i++) begin
            @(posedge clk);
            @(negedge clk);
        end
        chk("R8 rd_valid", rd_valid, 1);
        chk("R8 rd_data", rd_data, 8'h3C);
        @(posedge clk);
        @(posedge clk);
        @(negedge clk);
        chk("R9 idle", busy, 0);
        oe_m = 1'b0;
        repeat (50) @(posedge clk);
        do_write(2'b01, 8'hC3);

        if (!finished) begin
            finished = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule